// File: doc/BRIEF.md
# Eight-Function Mode-Selected ALU

This block is a purely combinational arithmetic and logic unit. It takes two operand words and a three-bit function code and returns a result word with two status flags: carry and zero. The top bit of the function code chooses the group of operations. The two lower bits choose one of four operations inside that group.

The arithmetic group has four operations: add with carry input, subtract, increment and decrement. The logic group has four operations: inclusive OR, AND, exclusive OR, and inversion of the first operand. Carry has meaning only for arithmetic operations. The operand width is a parameter and defaults to four bits.

Top module: `mode_alu`

## Requirements
- R1: `fsel[2]` selects the group of operations: 0 selects arithmetic and 1 selects logic. `fsel[1:0]` selects the operation inside that group.
- R2: With `fsel` = 000, `{cy_out, y}` equals `a + b + cy_in`, computed at W+1 bits.
- R3: With `fsel` = 001, `y` equals `a - b` modulo 2^W, computed as `a + ~b + 1`. `cy_out` is 1 exactly when `a >= b` (no borrow).
- R4: With `fsel` = 010, `y` equals `a + 1` modulo 2^W. `cy_out` is 1 only when `a` is all ones.
- R5: With `fsel` = 011, `y` equals `a - 1` modulo 2^W, computed as `a` plus all ones. `cy_out` is 1 unless `a` is zero.
- R6: With `fsel` = 100, `y` is `a | b`. With 101, `y` is `a & b`. With 110, `y` is `a ^ b`.
- R7: With `fsel` = 111, `y` is `~a`, and `b` has no effect.
- R8: In the logic group (`fsel[2]` = 1), `cy_out` is 0.
- R9: `zf` is 1 exactly when `y` is zero, for every function code.
- R10: `cy_in` affects neither `y` nor `cy_out` for any code other than 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| fsel | input | 3 | Function code: group bit and operation bits |
| cy_in | input | 1 | Carry input, used only by addition |
| y | output | W | Result |
| cy_out | output | 1 | Carry out; 1 means no borrow for subtract and decrement |
| zf | output | 1 | High when the result is zero |

## Verification
The bench builds the block at the default width of 4. At that width, every combination of the two operands, the carry input and all eight function codes can be applied: 4096 vectors in total. This reaches every carry and borrow boundary: all-ones increment, zero decrement, equal-operand subtraction, and every input pattern that gives a zero result. Both carry-input values are applied under every function code, so the operations that must ignore the carry input are shown to do so.

// File: rtl/mode_alu.sv
module mode_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   fsel,
  input  logic         cy_in,
  output logic [W-1:0] y,
  output logic         cy_out,
  output logic         zf
);
  logic [W-1:0] addend;
  logic         c0;
  logic [W:0]   sum;
  logic [W-1:0] lres;

  always_comb begin
    unique case (fsel[1:0])
      2'b00:   begin addend = b;         c0 = cy_in; end
      2'b01:   begin addend = ~b;        c0 = 1'b1;  end
      2'b10:   begin addend = '0;        c0 = 1'b1;  end
      default: begin addend = {W{1'b1}}; c0 = 1'b0;  end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, c0};

  always_comb begin
    unique case (fsel[1:0])
      2'b00:   lres = a | b;
      2'b01:   lres = a & b;
      2'b10:   lres = a ^ b;
      default: lres = ~a;
    endcase
  end

  assign y      = fsel[2] ? lres : sum[W-1:0];
  assign cy_out = ~fsel[2] & sum[W];
  assign zf     = ~|y;
endmodule

// File: rtl/mode_alu_chk.sv
module mode_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [2:0]   fsel,
  input logic         cy_in,
  input logic [W-1:0] y,
  input logic         cy_out,
  input logic         zf
);
  logic [W:0] wide_add;
  assign wide_add = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cy_in};

  always_comb begin
    if (fsel[2]) p_logic_nocarry_r8: assert (!cy_out);
    if (fsel == 3'b000) p_add_sum_r2: assert ({cy_out, y} == wide_add);
    if (fsel == 3'b001) p_sub_noborrow_r3: assert (cy_out == (a >= b));
    if (fsel == 3'b010) p_inc_wrap_r4: assert (cy_out == (&a));
    if (fsel == 3'b111) p_invert_r7: assert (&(y ^ a));
    if (zf) p_zero_flag_r9: assert (y == '0);
  end
endmodule

bind mode_alu mode_alu_chk #(.W(W)) u_chk (
  .a(a), .b(b), .fsel(fsel), .cy_in(cy_in),
  .y(y), .cy_out(cy_out), .zf(zf)
);

// File: tb/sim_mode_alu.sv
module sim_mode_alu;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0] fsel = '0;
  logic cy_in = 1'b0;
  logic [W-1:0] y;
  logic cy_out, zf;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_alu #(.W(W)) u0 (
    .a(a), .b(b), .fsel(fsel), .cy_in(cy_in),
    .y(y), .cy_out(cy_out), .zf(zf)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, fsel, a, b, cy_in, act, exp);
    end
  endtask

  function automatic string tag_of(input int op, input int ci);
    if (ci == 1 && op != 0) return "R10";
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      7: return "R7";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > LIMIT && !done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int full = 1 << W;
    int mask = full - 1;
    @(posedge clk);
    check("R9 idle zero flag", int'(zf), 1);
    check("R2 idle result", int'(y), 0);
    for (int op = 0; op < 8; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int ia = 0; ia < full; ia++) begin
          for (int ib = 0; ib < full; ib++) begin
            int s, ef, ec;
            @(negedge clk);
            a = ia[W-1:0]; b = ib[W-1:0]; fsel = op[2:0]; cy_in = ci[0];
            @(posedge clk);
            #1;
            case (op)
              0: s = ia + ib + ci;
              1: s = ia + (mask - ib) + 1;
              2: s = ia + 1;
              3: s = ia + mask;
              4: s = ia | ib;
              5: s = ia & ib;
              6: s = ia ^ ib;
              default: s = mask - ia;
            endcase
            ef = s & mask;
            ec = (op < 4) ? ((s >> W) & 1) : 0;
            check(tag_of(op, ci), int'(y), ef);
            if (op >= 4) check("R1/R8 logic carry", int'(cy_out), 0);
            else check(tag_of(op, ci), int'(cy_out), ec);
            check("R9 zero flag", int'(zf), (ef == 0) ? 1 : 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule